// File: doc/BRIEF.md
# Instruction and Memory Barrier Sequencer

This block sits beside an in-order issue stage and a load/store unit and enforces two kinds of ordering. An instruction barrier first waits until every older instruction has retired, including any exception one of them raises. It then flushes all younger work and sends fetch to the instruction that follows the barrier. It does not wait for the store queue to drain. A memory barrier holds back every younger instruction until the older data accesses have completed. Its operand selects how strict it is: the value 1 gives a lighter I/O-ordering form that needs only the outstanding-access count to reach zero. Any other value gives full ordering, which also needs the store queue to be empty.

The issue stage presents a decoded barrier on `dec_valid` and keeps presenting it while `issue_stall` is high. Only one barrier can be pending at a time. A barrier that arrives while another is pending waits at issue until the first one has finished. If an older instruction raises an exception while a barrier is pending, the barrier is cancelled and fetch is redirected to the exception vector. A load that feeds a branch ahead of an instruction barrier is an older instruction, so it completes before any load behind the barrier can issue.

Top module: `barrier_seq`

## Requirements
- R1: After reset, `issue_stall` and `flush` are 0 and `redirect_addr` is 0.
- R2: A barrier is accepted on a clock edge where `dec_valid` is 1 and `issue_stall` is 0. `issue_stall` is 1 from the next cycle until the barrier finishes, and it is also 1 during any flush cycle.
- R3: An instruction barrier (`dec_is_mem`=0) finishes only after a cycle in which `older_inflight` is 0. In the cycle after that one, `flush` is 1 and `redirect_addr` equals the barrier's `dec_pc` + 4. `issue_stall` falls in the cycle after the flush.
- R4: An instruction barrier ignores `sq_empty` and `mem_outstanding`. It completes while the store queue is not empty and accesses are still outstanding.
- R5: A memory barrier (`dec_is_mem`=1) whose operand is not 1 keeps `issue_stall` at 1 until a cycle with `mem_outstanding`=0 and `sq_empty`=1. `issue_stall` is 0 in the cycle after that one.
- R6: A memory barrier whose operand is 1 releases `issue_stall` in the cycle after the first cycle with `mem_outstanding`=0, whatever the value of `sq_empty`.
- R7: If `older_exc` is 1 while a barrier is pending, the next cycle has `flush`=1 and `redirect_addr`=`exc_vector`. This takes priority over normal completion in the same cycle.
- R8: A second barrier presented while one is pending is not accepted. When it is still presented after the first barrier finishes, it is accepted and carries its own address.
- R9: `flush` is never 1 for two cycles in a row, and `redirect_addr` is 0 whenever `flush` is 0.
- R10: A memory barrier that finishes without an exception never raises `flush`.
- R11: `older_exc` while no barrier is pending has no effect on `flush` or `issue_stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded barrier is present at issue |
| dec_is_mem | input | 1 | 1 = memory barrier, 0 = instruction barrier |
| dec_mo | input | MOW | Memory barrier ordering operand |
| dec_pc | input | AW | Address of the barrier instruction |
| older_inflight | input | CW | Older instructions not yet retired |
| older_exc | input | 1 | An older instruction raised an exception |
| exc_vector | input | AW | Exception handler address |
| mem_outstanding | input | CW | Data accesses still in flight |
| sq_empty | input | 1 | Store queue is empty |
| issue_stall | output | 1 | Hold younger instructions at issue |
| flush | output | 1 | One-cycle purge of younger instructions |
| redirect_addr | output | AW | New fetch address, valid with `flush` |

## Verification
The assertions assume the issue stage keeps `dec_valid` high while it is stalled, and that `older_exc` only reports exceptions from instructions older than the pending barrier. They also assume the counts never increase for older work once a barrier is pending. The stimulus respects all of this. Counts only count down after a barrier is accepted, exceptions are raised only against a pending barrier or on an empty pipeline to show they are ignored, and a held second barrier stays on `dec_valid` until it is taken.

// File: rtl/barrier_seq.sv
module barrier_seq #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int MOW = 5,
  parameter int INSN_BYTES = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dec_valid,
  input  logic           dec_is_mem,
  input  logic [MOW-1:0] dec_mo,
  input  logic [AW-1:0]  dec_pc,
  input  logic [CW-1:0]  older_inflight,
  input  logic           older_exc,
  input  logic [AW-1:0]  exc_vector,
  input  logic [CW-1:0]  mem_outstanding,
  input  logic           sq_empty,
  output logic           issue_stall,
  output logic           flush,
  output logic [AW-1:0]  redirect_addr
);

  typedef enum logic [1:0] {S_IDLE, S_IBAR, S_MBAR} st_t;

  st_t st;
  logic light_q, flush_q;
  logic [AW-1:0] next_pc_q, redir_q;

  logic accept, ib_done, mb_done, cancel;

  assign accept  = dec_valid && !issue_stall;
  assign ib_done = (st == S_IBAR) && (older_inflight == '0);
  assign mb_done = (st == S_MBAR) && (mem_outstanding == '0) && (light_q || sq_empty);
  assign cancel  = (st != S_IDLE) && older_exc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      light_q   <= 1'b0;
      flush_q   <= 1'b0;
      next_pc_q <= '0;
      redir_q   <= '0;
    end else begin
      flush_q <= cancel || ib_done;
      if (cancel) begin
        st      <= S_IDLE;
        redir_q <= exc_vector;
      end else if (ib_done) begin
        st      <= S_IDLE;
        redir_q <= next_pc_q;
      end else if (mb_done) begin
        st <= S_IDLE;
      end else if (accept) begin
        st        <= dec_is_mem ? S_MBAR : S_IBAR;
        light_q   <= (dec_mo == MOW'(1));
        next_pc_q <= dec_pc + AW'(INSN_BYTES);
      end
    end
  end

  assign issue_stall   = (st != S_IDLE) || flush_q;
  assign flush         = flush_q;
  assign redirect_addr = flush_q ? redir_q : '0;

endmodule

// File: rtl/barrier_seq_chk.sv
module barrier_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int MOW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dec_valid,
  input logic           dec_is_mem,
  input logic [MOW-1:0] dec_mo,
  input logic [CW-1:0]  older_inflight,
  input logic           older_exc,
  input logic [CW-1:0]  mem_outstanding,
  input logic           sq_empty,
  input logic           issue_stall,
  input logic           flush,
  input logic [AW-1:0]  redirect_addr
);

  logic mb_pend, mb_light;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb_pend  <= 1'b0;
      mb_light <= 1'b0;
    end else if (dec_valid && !issue_stall) begin
      mb_pend  <= dec_is_mem;
      mb_light <= (dec_mo == MOW'(1));
    end else if (mb_pend && (older_exc || (mem_outstanding == '0 && (mb_light || sq_empty)))) begin
      mb_pend <= 1'b0;
    end
  end

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !flush); // R9
  AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !flush |-> redirect_addr == '0); // R9
  AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (!rst_n) flush |-> issue_stall); // R2
  AST_IB_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ($past(older_exc) || $past(older_inflight) == '0)); // R3
  AST_MB_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_pend && !mb_light && !sq_empty && !older_exc) |=> issue_stall); // R5
  AST_MB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_pend && mem_outstanding != '0 && !older_exc) |=> issue_stall); // R6
  AST_MB_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_pend && !older_exc) |=> !flush); // R10
  AST_IDLE_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_stall && !dec_valid) |=> !flush); // R11

endmodule

bind barrier_seq barrier_seq_chk #(.AW(AW), .CW(CW), .MOW(MOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_mem(dec_is_mem),
  .dec_mo(dec_mo), .older_inflight(older_inflight), .older_exc(older_exc),
  .mem_outstanding(mem_outstanding), .sq_empty(sq_empty),
  .issue_stall(issue_stall), .flush(flush), .redirect_addr(redirect_addr)
);

// File: tb/sim_barrier_seq.sv
module sim_barrier_seq;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int MOW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, dec_is_mem = 1'b0, older_exc = 1'b0, sq_empty = 1'b1;
  logic [MOW-1:0] dec_mo = '0;
  logic [AW-1:0] dec_pc = '0, exc_vector = '0;
  logic [CW-1:0] older_inflight = '0, mem_outstanding = '0;
  logic issue_stall, flush;
  logic [AW-1:0] redirect_addr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  barrier_seq #(.AW(AW), .CW(CW), .MOW(MOW)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_mem(dec_is_mem),
    .dec_mo(dec_mo), .dec_pc(dec_pc), .older_inflight(older_inflight),
    .older_exc(older_exc), .exc_vector(exc_vector), .mem_outstanding(mem_outstanding),
    .sq_empty(sq_empty), .issue_stall(issue_stall), .flush(flush),
    .redirect_addr(redirect_addr)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic st, input logic fl, input logic [AW-1:0] ra);
    chk(req, "issue_stall", AW'(issue_stall), AW'(st));
    chk(req, "flush", AW'(flush), AW'(fl));
    chk(req, "redirect_addr", redirect_addr, ra);
  endtask

  task automatic ib_run(input logic [AW-1:0] pc, input int w, input logic sq);
    dec_valid = 1; dec_is_mem = 0; dec_pc = pc; sq_empty = sq; mem_outstanding = 4'd3;
    older_inflight = CW'(w);
    tick();
    dec_valid = 0;
    expect_out("R2", 1, 0, '0);
    for (int rem = w; rem >= 0; rem--) begin
      older_inflight = CW'(rem);
      tick();
      if (rem == 0) expect_out(sq ? "R3" : "R4", 1, 1, pc + 4);
      else expect_out("R3", 1, 0, '0);
    end
    tick();
    expect_out("R3", 0, 0, '0);
    mem_outstanding = 0; sq_empty = 1;
  endtask

  task automatic mb_run(input logic [MOW-1:0] mo, input int w, input int s);
    bit light;
    light = (mo == MOW'(1));
    dec_valid = 1; dec_is_mem = 1; dec_mo = mo; dec_pc = 32'h0000_0400;
    mem_outstanding = CW'(w); sq_empty = (s == 0);
    tick();
    dec_valid = 0;
    expect_out("R2", 1, 0, '0);
    for (int c = 0; c < w + s + 3; c++) begin
      bit fin;
      mem_outstanding = (c < w) ? CW'(w - c) : '0;
      sq_empty = (c >= s);
      fin = (c >= w) && (light || (c >= s));
      tick();
      if (fin) begin
        expect_out(light ? "R6" : "R5", 0, 0, '0);
        break;
      end else begin
        expect_out(light ? "R6" : "R5", 1, 0, '0);
        chk("R10", "flush", AW'(flush), '0);
      end
    end
    mem_outstanding = 0; sq_empty = 1;
  endtask

  initial begin
    repeat (3) tick();
    expect_out("R1", 0, 0, '0);
    rst_n = 1;
    tick();
    expect_out("R1", 0, 0, '0);

    for (int w = 0; w < 4; w++)
      for (int sq = 0; sq < 2; sq++)
        ib_run(32'h1000 + 32'(w * 16 + sq * 8), w, sq[0]);

    for (int mo = 0; mo < 4; mo++)
      for (int w = 0; w < 3; w++)
        for (int s = 0; s < 3; s++)
          mb_run(MOW'(mo), w, s);

    // R7: exception during an instruction barrier wait
    dec_valid = 1; dec_is_mem = 0; dec_pc = 32'h2000; older_inflight = 2;
    tick();
    dec_valid = 0; older_exc = 1; exc_vector = 32'h0000_0700;
    tick();
    older_exc = 0;
    expect_out("R7", 1, 1, 32'h0000_0700);
    tick();
    expect_out("R7", 0, 0, '0);

    // R7: exception and completion in the same cycle
    dec_valid = 1; dec_pc = 32'h2100; older_inflight = 1;
    tick();
    dec_valid = 0; older_inflight = 0; older_exc = 1; exc_vector = 32'h0000_0900;
    tick();
    older_exc = 0;
    expect_out("R7", 1, 1, 32'h0000_0900);
    tick();

    // R7: exception during a memory barrier wait
    dec_valid = 1; dec_is_mem = 1; dec_mo = 0; mem_outstanding = 2;
    tick();
    dec_valid = 0; older_exc = 1; exc_vector = 32'h0000_0500;
    tick();
    older_exc = 0; mem_outstanding = 0; dec_is_mem = 0;
    expect_out("R7", 1, 1, 32'h0000_0500);
    tick();
    expect_out("R7", 0, 0, '0);

    // R11: exception with nothing pending
    older_exc = 1;
    tick();
    older_exc = 0;
    expect_out("R11", 0, 0, '0);
    tick();
    expect_out("R11", 0, 0, '0);

    // R8: second barrier held at issue
    dec_valid = 1; dec_is_mem = 0; dec_pc = 32'h3000; older_inflight = 1;
    tick();
    dec_pc = 32'h3040;
    expect_out("R8", 1, 0, '0);
    older_inflight = 0;
    tick();
    expect_out("R8", 1, 1, 32'h3004);
    tick();
    expect_out("R8", 0, 0, '0);
    tick();
    dec_valid = 0;
    expect_out("R8", 1, 0, '0);
    tick();
    expect_out("R8", 1, 1, 32'h3044);
    tick();
    expect_out("R8", 0, 0, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule